// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural integer registers and the status registers of a 32-bit processor core. Instructions name sixteen architectural registers. The physical storage behind some of them depends on the processor mode presented on the mode input. A fast-interrupt mode has a private copy of the upper general registers. Every privileged mode has its own stack pointer, its own link register and a saved status register. The program counter and the current status register are single registers that all modes share.

The core drives a 5-bit mode code every cycle. It reads two operands combinationally through two read ports and writes one result per clock edge. Ten mode codes are accepted. Four of them are 26-bit compatibility modes, and each of these maps onto exactly the same storage as its 32-bit counterpart. The saved status register of the current mode has its own read path and its own write path. The current status register is written and read directly. Decode, the ALU, exception sequencing and program counter increment live outside this block.

Top module: `bankrf_top`

## Requirements
- R1: Architectural registers 0 to 7 map to one physical set that is shared by every mode. A value written in any mode reads back in every other mode.
- R2: Registers 8 to 12 have a private copy that is used only while the mode selects the fast-interrupt bank (codes 10001 and 00001). Every other mode uses the common copy.
- R3: Registers 13 and 14 have six copies: a common one and one each for fast-interrupt, interrupt, supervisor, abort and undefined modes. Every other mode uses the common copy.
- R4: Register 15 and the current status register are single physical registers, shared by all modes.
- R5: Each 26-bit mode (00000, 00001, 00010, 00011) selects exactly the same storage as its 32-bit counterpart (10000, 10001, 10010, 10011).
- R6: Mode codes: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, plus the four 26-bit codes of R5. Any other code selects the user banks.
- R7: Each privileged mode has its own saved status register. A write with the saved-status write enable in that mode is visible on the saved-status output from the next cycle on, and only in that mode.
- R8: In user modes the saved-status output shows the current status register, and a saved-status write changes no register.
- R9: Reads are combinational from the stored state. A read of a register that is being written in the same cycle returns the old value, and the new value appears after the clock edge. With no write enable, no register changes.
- R10: Reset clears every general and saved status register to zero and loads the current status register with 0x00000013, which is the supervisor code in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| ra_addr_i | input | 4 | Read port A architectural register |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 4 | Read port B architectural register |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Write architectural register |
| wr_data_i | input | 32 | Write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status register |
| spsr_we_i | input | 1 | Saved status write enable (current mode) |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status of current mode, or current status in user modes |

## Verification
A wrong bank selection shows up as a stale or foreign value on a read port. This is visible on the first read of that register in a mode other than the one that wrote it, so the bench reads every register in every mode after writes spread across modes. A saved-status write that leaks from user mode appears as a changed saved-status value in a privileged mode. A broken read-during-write path shows the new value one cycle early, in the very cycle of the write.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR26 = 5'b00000;
  localparam logic [MODE_W-1:0] MODE_FIQ26 = 5'b00001;
  localparam logic [MODE_W-1:0] MODE_IRQ26 = 5'b00010;
  localparam logic [MODE_W-1:0] MODE_SVC26 = 5'b00011;
  localparam logic [MODE_W-1:0] MODE_USR   = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ   = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ   = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC   = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT   = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND   = 5'b11011;

  // Bank order matters: privileged banks are numbered 1..5
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int NUM_PRIV = 5;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    bank_e b;
    case (m)
      MODE_FIQ, MODE_FIQ26: b = BK_FIQ;
      MODE_IRQ, MODE_IRQ26: b = BK_IRQ;
      MODE_SVC, MODE_SVC26: b = BK_SVC;
      MODE_ABT:             b = BK_ABT;
      MODE_UND:             b = BK_UND;
      default:              b = BK_USR;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
#(
  parameter int AW = 4,
  parameter int PW = 5
) (
  input  bank_e         bank_i,
  input  logic [AW-1:0] arch_i,
  output logic [PW-1:0] phys_o
);

  localparam int NARCH     = 1 << AW;
  localparam int FIQ_LO    = 8;
  localparam int FIQ_HI    = 12;
  localparam int SP_REG    = 13;
  localparam int LR_REG    = 14;
  localparam int FIQ_BASE  = NARCH;
  localparam int PRIV_BASE = FIQ_BASE + (FIQ_HI - FIQ_LO + 1);

  always_comb begin
    int a;
    int b;
    a = int'(arch_i);
    b = int'(bank_i);
    phys_o = PW'(a);
    if (a >= FIQ_LO && a <= FIQ_HI && bank_i == BK_FIQ) begin
      phys_o = PW'(FIQ_BASE + a - FIQ_LO);
    end else if ((a == SP_REG || a == LR_REG) && bank_i != BK_USR) begin
      phys_o = PW'(PRIV_BASE + 2 * (b - 1) + (a - SP_REG));
    end
  end

endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int DW    = 32,
  parameter int PW    = 5,
  parameter int NPHYS = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ra_idx_i,
  input  logic [PW-1:0] rb_idx_i,
  input  logic          we_i,
  input  logic [PW-1:0] w_idx_i,
  input  logic [DW-1:0] w_data_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o
);

  logic [DW-1:0] regs_q [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_entry
    logic          en;
    logic [DW-1:0] nxt;

    assign en = we_i && (w_idx_i == PW'(g));

    always_comb begin
      nxt = regs_q[g];
      if (en) nxt = w_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= nxt;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];

endmodule

// File: rtl/bankrf_psr.sv
module bankrf_psr
  import bankrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_e         bank_i,
  input  logic          cpsr_we_i,
  input  logic [DW-1:0] cpsr_wdata_i,
  input  logic          spsr_we_i,
  input  logic [DW-1:0] spsr_wdata_i,
  output logic [DW-1:0] cpsr_o,
  output logic [DW-1:0] spsr_o
);

  localparam int SW = $clog2(NUM_PRIV);
  localparam logic [DW-1:0] CPSR_RST = DW'(MODE_SVC);

  logic [DW-1:0] cpsr_q, cpsr_d;
  logic [DW-1:0] spsr_q [NUM_PRIV];
  logic          priv;
  logic [SW-1:0] sel;

  assign priv = (bank_i != BK_USR);
  assign sel  = priv ? SW'(int'(bank_i) - 1) : '0;

  always_comb begin
    cpsr_d = cpsr_q;
    if (cpsr_we_i) cpsr_d = cpsr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpsr_q <= CPSR_RST;
    else        cpsr_q <= cpsr_d;
  end

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_spsr
    logic          en;
    logic [DW-1:0] nxt;

    assign en = spsr_we_i && priv && (sel == SW'(g));

    always_comb begin
      nxt = spsr_q[g];
      if (en) nxt = spsr_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spsr_q[g] <= '0;
      else        spsr_q[g] <= nxt;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = priv ? spsr_q[sel] : cpsr_q;

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     ra_addr_i,
  output logic [DW-1:0]     ra_data_o,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DW-1:0]     rb_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              cpsr_we_i,
  input  logic [DW-1:0]     cpsr_wdata_i,
  output logic [DW-1:0]     cpsr_o,
  input  logic              spsr_we_i,
  input  logic [DW-1:0]     spsr_wdata_i,
  output logic [DW-1:0]     spsr_o
);

  localparam int NARCH = 1 << AW;
  localparam int NFIQ  = 5;
  localparam int NPRIV = 2 * NUM_PRIV;
  localparam int NPHYS = NARCH + NFIQ + NPRIV;
  localparam int PW    = $clog2(NPHYS);

  bank_e         bank;
  logic [PW-1:0] ra_idx, rb_idx, w_idx;

  assign bank = mode_to_bank(mode_i);

  bankrf_map #(.AW(AW), .PW(PW)) u_map_a (
    .bank_i(bank), .arch_i(ra_addr_i), .phys_o(ra_idx)
  );
  bankrf_map #(.AW(AW), .PW(PW)) u_map_b (
    .bank_i(bank), .arch_i(rb_addr_i), .phys_o(rb_idx)
  );
  bankrf_map #(.AW(AW), .PW(PW)) u_map_w (
    .bank_i(bank), .arch_i(wr_addr_i), .phys_o(w_idx)
  );

  bankrf_store #(.DW(DW), .PW(PW), .NPHYS(NPHYS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx_i(ra_idx), .rb_idx_i(rb_idx),
    .we_i(wr_en_i), .w_idx_i(w_idx), .w_data_i(wr_data_i),
    .ra_data_o(ra_data_o), .rb_data_o(rb_data_o)
  );

  bankrf_psr #(.DW(DW)) u_psr (
    .clk(clk), .rst_n(rst_n), .bank_i(bank),
    .cpsr_we_i(cpsr_we_i), .cpsr_wdata_i(cpsr_wdata_i),
    .spsr_we_i(spsr_we_i), .spsr_wdata_i(spsr_wdata_i),
    .cpsr_o(cpsr_o), .spsr_o(spsr_o)
  );

endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk
  import bankrf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic [AW-1:0]     ra_addr_i,
  input logic [DW-1:0]     ra_data_o,
  input logic              wr_en_i,
  input logic [AW-1:0]     wr_addr_i,
  input logic [DW-1:0]     wr_data_i,
  input logic              cpsr_we_i,
  input logic [DW-1:0]     cpsr_o,
  input logic              spsr_we_i,
  input logic [DW-1:0]     spsr_wdata_i,
  input logic [DW-1:0]     spsr_o
);

  logic user_mode;
  assign user_mode = (mode_to_bank(mode_i) == BK_USR);

  // R1
  shared_low_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i < AW'(8)) |=>
      (ra_addr_i != $past(wr_addr_i) || ra_data_o == $past(wr_data_i)));

  // R4
  cpsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_we_i |=> $stable(cpsr_o));

  // R7
  spsr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spsr_we_i && !user_mode) |=>
      (mode_i != $past(mode_i) || spsr_o == $past(spsr_wdata_i)));

  // R8
  user_spsr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> spsr_o == cpsr_o);

  // R9
  write_lands_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mode_i != $past(mode_i) || ra_addr_i != $past(wr_addr_i)
                 || ra_data_o == $past(wr_data_i)));

endmodule

bind bankrf_top bankrf_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
  .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .cpsr_we_i(cpsr_we_i), .cpsr_o(cpsr_o),
  .spsr_we_i(spsr_we_i), .spsr_wdata_i(spsr_wdata_i), .spsr_o(spsr_o)
);

// File: tb/bankrf_top_tb_top.sv
`timescale 1ns/1ps
module bankrf_top_tb_top;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    mode;
  logic [AW-1:0] ra_addr, rb_addr, wr_addr;
  logic [DW-1:0] ra_data, rb_data, wr_data;
  logic          wr_en, cpsr_we, spsr_we;
  logic [DW-1:0] cpsr_wdata, spsr_wdata, cpsr, spsr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state: key 0..5 per architectural register
  logic [DW-1:0] m_reg [6][16];
  logic [DW-1:0] m_spsr [6];
  logic [DW-1:0] m_cpsr;

  always #2.5 clk = ~clk;

  bankrf_top #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .ra_addr_i(ra_addr), .ra_data_o(ra_data),
    .rb_addr_i(rb_addr), .rb_data_o(rb_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpsr_we_i(cpsr_we), .cpsr_wdata_i(cpsr_wdata), .cpsr_o(cpsr),
    .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .spsr_o(spsr)
  );

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'b10001, 5'b00001: return 1;
      5'b10010, 5'b00010: return 2;
      5'b10011, 5'b00011: return 3;
      5'b10111:           return 4;
      5'b11011:           return 5;
      default:            return 0;
    endcase
  endfunction

  function automatic int key_of(input logic [4:0] m, input int a);
    int b;
    b = bank_of(m);
    if (a < 8 || a == 15) return 0;
    if (a <= 12) return (b == 1) ? 1 : 0;
    return b;
  endfunction

  function automatic logic [4:0] pick_mode(input int i);
    case (i)
      0: return 5'b10000;  1: return 5'b10001;  2: return 5'b10010;
      3: return 5'b10011;  4: return 5'b10111;  5: return 5'b11011;
      6: return 5'b00000;  7: return 5'b00001;  8: return 5'b00010;
      9: return 5'b00011;  default: return 5'b01010;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [4:0] m, input int a);
    return m_reg[key_of(m, a)][a];
  endfunction

  function automatic logic [DW-1:0] exp_spsr(input logic [4:0] m);
    int b;
    b = bank_of(m);
    return (b == 0) ? m_cpsr : m_spsr[b];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; cpsr_we = 0; spsr_we = 0;
  endtask

  // apply current inputs over one edge and update the reference
  task automatic tick();
    @(posedge clk);
    if (wr_en)   m_reg[key_of(mode, int'(wr_addr))][wr_addr] = wr_data;
    if (spsr_we && bank_of(mode) != 0) m_spsr[bank_of(mode)] = spsr_wdata;
    if (cpsr_we) m_cpsr = cpsr_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [4:0] m, input int a, input logic [DW-1:0] d);
    mode = m; wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
  endtask

  task automatic rd_chk(input string req, input logic [4:0] m, input int a);
    mode = m; ra_addr = AW'(a); rb_addr = AW'(a);
    #1;
    chk(req, ra_data, exp_rd(m, a));
    chk(req, rb_data, exp_rd(m, a));
  endtask

  task automatic sweep(input string req);
    for (int mi = 0; mi < 11; mi++)
      for (int a = 0; a < 16; a++) rd_chk(req, pick_mode(mi), a);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 6; k++) begin
      m_spsr[k] = '0;
      for (int a = 0; a < 16; a++) m_reg[k][a] = '0;
    end
    m_cpsr = 32'h0000_0013;
    rst_n = 0; mode = 5'b10000; ra_addr = '0; rb_addr = '0;
    wr_addr = '0; wr_data = '0; cpsr_wdata = '0; spsr_wdata = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10: reset state
    sweep("R10");
    mode = 5'b10000; #1;
    chk("R10", cpsr, 32'h0000_0013);
    for (int mi = 1; mi < 6; mi++) begin
      mode = pick_mode(mi); #1;
      chk("R10", spsr, 32'h0);
    end

    // R1: low register written in abort, seen everywhere
    wr(5'b10111, 3, 32'hA5A5_0003);
    for (int mi = 0; mi < 11; mi++) rd_chk("R1", pick_mode(mi), 3);

    // R2: fast-interrupt private copy of register 10
    wr(5'b10001, 10, 32'hF10F_0010);
    wr(5'b10000, 10, 32'h0050_0010);
    rd_chk("R2", 5'b10001, 10);
    rd_chk("R2", 5'b10010, 10);
    chk("R2", ra_data, 32'h0050_0010);

    // R3: distinct stack pointer per bank
    for (int mi = 0; mi < 6; mi++) wr(pick_mode(mi), 13, 32'h1300_0000 + mi);
    for (int mi = 0; mi < 6; mi++) begin
      rd_chk("R3", pick_mode(mi), 13);
      chk("R3", ra_data, 32'h1300_0000 + mi);
    end

    // R4: register 15 and status shared
    wr(5'b11011, 15, 32'h0000_8000);
    rd_chk("R4", 5'b10001, 15);
    chk("R4", ra_data, 32'h0000_8000);

    // R5: 26-bit alias of interrupt link register
    wr(5'b00010, 14, 32'h2614_0002);
    rd_chk("R5", 5'b10010, 14);
    chk("R5", ra_data, 32'h2614_0002);

    // R6: unlisted code behaves as user
    wr(5'b01010, 14, 32'h6666_0014);
    rd_chk("R6", 5'b10000, 14);
    chk("R6", ra_data, 32'h6666_0014);

    // R7: saved status per mode
    mode = 5'b10011; spsr_we = 1; spsr_wdata = 32'h5550_0013; tick();
    mode = 5'b10011; #1; chk("R7", spsr, 32'h5550_0013);
    mode = 5'b10010; #1; chk("R7", spsr, 32'h0);

    // R8: user saved-status write ignored, view equals status
    mode = 5'b10000; spsr_we = 1; spsr_wdata = 32'hBAD0_BAD0; tick();
    mode = 5'b10000; #1; chk("R8", spsr, cpsr);
    chk("R8", cpsr, 32'h0000_0013);
    for (int mi = 1; mi < 6; mi++) begin
      mode = pick_mode(mi); #1;
      chk("R8", spsr, exp_spsr(mode));
    end

    // R9: read during write returns old value, then new
    mode = 5'b10011; ra_addr = 4'd13; wr_en = 1; wr_addr = 4'd13;
    wr_data = 32'hDEAD_0013; #1;
    chk("R9", ra_data, 32'h1300_0003);
    tick();
    rd_chk("R9", 5'b10011, 13);
    chk("R9", ra_data, 32'hDEAD_0013);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      mode    = pick_mode($urandom_range(0, 10));
      ra_addr = AW'($urandom_range(0, 15));
      rb_addr = AW'($urandom_range(0, 15));
      wr_en   = ($urandom_range(0, 3) != 0);
      wr_addr = AW'($urandom_range(0, 15));
      wr_data = $urandom();
      spsr_we = ($urandom_range(0, 5) == 0);
      spsr_wdata = $urandom();
      cpsr_we = ($urandom_range(0, 7) == 0);
      cpsr_wdata = $urandom();
      #1;
      chk("R9", ra_data, exp_rd(mode, int'(ra_addr)));
      chk("R9", rb_data, exp_rd(mode, int'(rb_addr)));
      chk("R4", cpsr, m_cpsr);
      chk("R7", spsr, exp_spsr(mode));
      tick();
    end
    sweep("R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule